// File: doc/BRIEF.md
# Clock Reference Selector

This block decides which of four reference clock inputs feeds a downstream PLL. Software chooses either a direct manual pick through a 2-bit select field or automatic arbitration. In automatic mode the block uses per-input validity flags from external clock monitors, a programmable 2-bit priority for each input and a revertive-enable bit.

The outputs are the index of the active input, a holdover flag and a single-cycle switch-event pulse. The PLL uses the holdover flag to freeze its frequency when no reference can be trusted. It uses the pulse to start its own ramp or pull-in behaviour. The block does not qualify the clocks. It arbitrates only on the flags it receives, and everything runs on one system clock with a synchronous reset.

All outputs are registered. The inputs sampled at a rising edge decide the outputs that appear just after that edge.

Top module: `refclk_arbiter`

## Requirements
- R1: With `auto_mode` low, `man_sel` chooses the input directly: 2'b00 selects 0, 2'b01 selects 1, 2'b10 selects 2 and 2'b11 selects 3. `holdover` is low in manual mode.
- R2: In automatic mode, while `holdover` is low, `active_idx` never names an input whose `valid` bit was low at the edge that set it.
- R3: In automatic mode, when all `valid` bits are low, `holdover` goes high and `active_idx` keeps its last value.
- R4: With `revertive` high, automatic mode always selects the best valid input, including when a better input becomes valid.
- R5: With `revertive` low, the current input stays selected while its `valid` bit is high, even if a better input becomes valid.
- R6: With `revertive` low, when the current input loses validity, the best valid input is selected.
- R7: The priority of input i is `prio[2i+1:2i]`, and a lower value ranks higher. When two inputs have equal values, the lower index wins.
- R8: On leaving holdover, the best valid input is selected and `holdover` drops on the same edge, whatever the `revertive` setting.
- R9: `switch_event` is high for exactly the cycle after each edge that changes `active_idx` or `holdover`. It stays low while the selection is stable.
- R10: While `rst` is high, the outputs are `holdover`=1, `active_idx`=0 and `switch_event`=0. Selection is evaluated at the first edge with `rst` low.
- R11: A change of `auto_mode` takes effect at the next edge, and that edge evaluates the selection under the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_mode | input | 1 | 1 = automatic arbitration, 0 = manual |
| man_sel | input | 2 | Manual input index |
| valid | input | 4 | Per-input validity flags |
| prio | input | 8 | Per-input priority, 2 bits each, lower ranks higher |
| revertive | input | 1 | Revertive policy enable |
| active_idx | output | 2 | Index of the active input |
| holdover | output | 1 | No usable reference in automatic mode |
| switch_event | output | 1 | One-cycle pulse on any selection change |

## Verification
The state is just the registered index and holdover bit, so any wrong internal decision appears on `active_idx` or `holdover` one edge after the inputs that caused it. Two cases can stay hidden until a later step. A stale index during holdover shows only when holdover ends under the non-revertive policy. A wrongly kept input shows only once a better input appears. For this reason, the sweep applies every ordered pair of validity patterns under each policy and several priority sets. A missing or extra pulse on `switch_event` is visible in the same cycle as the change it belongs to.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic {MODE_MANUAL = 1'b0, MODE_AUTO = 1'b1} refsel_mode_e;

  // Ranking key: priority value in the upper part, index below, so that
  // a plain "smaller key wins" comparison also breaks ties by index.
  function automatic int rank_key(input int prio_val, input int idx, input int n_in);
    return prio_val * n_in + idx;
  endfunction
endpackage

// File: rtl/refsel_pick.sv
module refsel_pick #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 2,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0]        valid,
  input  logic [N_IN*PRIO_W-1:0] prio,
  output logic [SEL_W-1:0]       best_idx,
  output logic                   any_valid
);
  import refsel_pkg::*;

  int keys [N_IN];

  for (genvar g = 0; g < N_IN; g++) begin : g_key
    always_comb keys[g] = rank_key(int'(prio[g*PRIO_W +: PRIO_W]), g, N_IN);
  end

  always_comb begin
    int best_key;
    best_key  = 0;
    best_idx  = '0;
    any_valid = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (valid[i] && (!any_valid || keys[i] < best_key)) begin
        best_key  = keys[i];
        best_idx  = SEL_W'(i);
        any_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/refsel_policy.sv
module refsel_policy #(
  parameter int N_IN   = 4,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  refsel_pkg::refsel_mode_e mode,
  input  logic [SEL_W-1:0]         man_sel,
  input  logic                     revertive,
  input  logic [N_IN-1:0]          valid,
  input  logic [SEL_W-1:0]         cur_idx,
  input  logic                     cur_hold,
  input  logic [SEL_W-1:0]         best_idx,
  input  logic                     any_valid,
  output logic [SEL_W-1:0]         nxt_idx,
  output logic                     nxt_hold,
  output logic                     cur_still_valid
);
  import refsel_pkg::*;

  assign cur_still_valid = !cur_hold && valid[cur_idx];

  always_comb begin
    nxt_idx  = cur_idx;
    nxt_hold = cur_hold;
    if (mode == MODE_MANUAL) begin
      nxt_idx  = man_sel;
      nxt_hold = 1'b0;
    end else if (!any_valid) begin
      nxt_hold = 1'b1;
    end else if (!revertive && cur_still_valid) begin
      nxt_idx  = cur_idx;
      nxt_hold = 1'b0;
    end else begin
      nxt_idx  = best_idx;
      nxt_hold = 1'b0;
    end
  end
endmodule

// File: rtl/refsel_state.sv
module refsel_state #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] nxt_idx,
  input  logic             nxt_hold,
  output logic [SEL_W-1:0] cur_idx,
  output logic             cur_hold,
  output logic             evt,
  output logic             sel_change
);
  assign sel_change = (nxt_idx != cur_idx) || (nxt_hold != cur_hold);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx  <= '0;
      cur_hold <= 1'b1;
      evt      <= 1'b0;
    end else begin
      cur_idx  <= nxt_idx;
      cur_hold <= nxt_hold;
      evt      <= sel_change;
    end
  end
endmodule

// File: rtl/refclk_arbiter.sv
module refclk_arbiter #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 2,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   auto_mode,
  input  logic [SEL_W-1:0]       man_sel,
  input  logic [N_IN-1:0]        valid,
  input  logic [N_IN*PRIO_W-1:0] prio,
  input  logic                   revertive,
  output logic [SEL_W-1:0]       active_idx,
  output logic                   holdover,
  output logic                   switch_event
);
  import refsel_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [SEL_W-1:0] best_idx;
  logic             any_valid;
  logic [SEL_W-1:0] nxt_idx;
  logic             nxt_hold;
  logic             cur_still_valid;
  logic             sel_change;
  refsel_mode_e     mode;

  assign mode = auto_mode ? MODE_AUTO : MODE_MANUAL;

  refsel_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_pick (
    .valid    (valid),
    .prio     (prio),
    .best_idx (best_idx),
    .any_valid(any_valid)
  );

  refsel_policy #(.N_IN(N_IN)) u_policy (
    .mode           (mode),
    .man_sel        (man_sel),
    .revertive      (revertive),
    .valid          (valid),
    .cur_idx        (active_idx),
    .cur_hold       (holdover),
    .best_idx       (best_idx),
    .any_valid      (any_valid),
    .nxt_idx        (nxt_idx),
    .nxt_hold       (nxt_hold),
    .cur_still_valid(cur_still_valid)
  );

  refsel_state #(.SEL_W(SEL_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .nxt_idx   (nxt_idx),
    .nxt_hold  (nxt_hold),
    .cur_idx   (active_idx),
    .cur_hold  (holdover),
    .evt       (switch_event),
    .sel_change(sel_change)
  );
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk #(
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             auto_mode,
  input logic [SEL_W-1:0] man_sel,
  input logic [N_IN-1:0]  valid,
  input logic             revertive,
  input logic [SEL_W-1:0] active_idx,
  input logic             holdover,
  input logic             switch_event
);
  logic             started;
  logic             auto_q, rev_q, hold_q;
  logic [SEL_W-1:0] man_q, idx_q;
  logic [N_IN-1:0]  valid_q;

  always_ff @(posedge clk) begin
    started <= !rst;
    auto_q  <= auto_mode;
    rev_q   <= revertive;
    man_q   <= man_sel;
    valid_q <= valid;
    idx_q   <= active_idx;
    hold_q  <= holdover;
  end

  // R10
  reset_state_chk: assert property (@(posedge clk) $past(rst) |-> (holdover && active_idx == '0 && !switch_event));

  // R1
  manual_map_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !auto_q) |-> (active_idx == man_q && !holdover));

  // R2
  never_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (started && auto_q && !holdover) |-> valid_q[active_idx]);

  // R3
  enter_holdover_chk: assert property (@(posedge clk) disable iff (rst)
    (started && auto_q && valid_q == '0) |-> (holdover && active_idx == idx_q));

  // R5
  nonrev_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (started && auto_q && !rev_q && !hold_q && valid_q[idx_q]) |-> (active_idx == idx_q && !holdover));

  // R9
  event_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    started |-> (switch_event == ((active_idx != idx_q) || (holdover != hold_q))));
endmodule

bind refclk_arbiter refsel_chk #(.N_IN(N_IN), .SEL_W(SEL_W)) u_refsel_chk (
  .clk         (clk),
  .rst         (rst),
  .auto_mode   (auto_mode),
  .man_sel     (man_sel),
  .valid       (valid),
  .revertive   (revertive),
  .active_idx  (active_idx),
  .holdover    (holdover),
  .switch_event(switch_event)
);

// File: tb/test_refclk_arbiter.sv
module test_refclk_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       auto_mode = 1'b0;
  logic [1:0] man_sel = '0;
  logic [3:0] valid = '0;
  logic [7:0] prio = '0;
  logic       revertive = 1'b0;
  logic [1:0] active_idx;
  logic       holdover;
  logic       switch_event;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected state
  logic [1:0] e_idx = 2'd0;
  logic       e_hold = 1'b1;
  logic       e_evt = 1'b0;

  always #2 clk = ~clk;

  refclk_arbiter i_refclk_arbiter (
    .clk(clk), .rst(rst), .auto_mode(auto_mode), .man_sel(man_sel),
    .valid(valid), .prio(prio), .revertive(revertive),
    .active_idx(active_idx), .holdover(holdover), .switch_event(switch_event)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // best valid input: weight = priority*4 + index, smallest wins
  function automatic int best_of(input logic [3:0] v, input logic [7:0] p);
    int w = 1000;
    int b = -1;
    for (int i = 0; i < 4; i++)
      if (v[i] && (p[2*i +: 2] * 4 + i) < w) begin
        w = p[2*i +: 2] * 4 + i;
        b = i;
      end
    return b;
  endfunction

  task automatic step(input logic am, input logic [1:0] ms, input logic [3:0] v,
                      input logic rv, input logic [7:0] p, input string force_tag);
    string tag;
    logic [1:0] n_idx;
    logic n_hold;
    int b;
    @(negedge clk);
    auto_mode = am; man_sel = ms; valid = v; revertive = rv; prio = p;
    b = best_of(v, p);
    n_idx = e_idx; n_hold = e_hold;
    if (!am) begin
      n_idx = ms; n_hold = 0; tag = "R1";
    end else if (b < 0) begin
      n_hold = 1; tag = "R3";
    end else if (e_hold) begin
      n_idx = 2'(b); n_hold = 0; tag = "R8";
    end else if (rv) begin
      n_idx = 2'(b); n_hold = 0; tag = "R4";
    end else if (v[e_idx]) begin
      n_hold = 0; tag = "R5";
    end else begin
      n_idx = 2'(b); n_hold = 0; tag = "R6";
    end
    if (force_tag != "") tag = force_tag;
    e_evt = (n_idx != e_idx) || (n_hold != e_hold);
    e_idx = n_idx; e_hold = n_hold;
    @(posedge clk); #1;
    check(tag, int'(holdover), int'(e_hold));
    check(tag, int'(active_idx), int'(e_idx));
    check("R9", int'(switch_event), int'(e_evt));
    if (am && !holdover) check("R2", int'(v[active_idx]), 1);
  endtask

  initial begin
    logic [7:0] pset [4];
    pset[0] = 8'b00_00_00_00;
    pset[1] = 8'b00_01_10_11;
    pset[2] = 8'b01_00_01_00;
    pset[3] = 8'b10_01_01_11;
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R10", int'(holdover), 1);
    check("R10", int'(active_idx), 0);
    check("R10", int'(switch_event), 0);
    // R10: first edge after release evaluates automatic selection
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 2'd0, 4'b0100, 1'b1, 8'h00, "R10");
    // R1: manual sweep, invalid flags ignored
    for (int m = 0; m < 4; m++) step(1'b0, 2'(m), 4'b0000, 1'b0, 8'h00, "R1");
    // R11: mode change, auto picks best at the next edge
    step(1'b1, 2'd3, 4'b0011, 1'b0, 8'h00, "R11");
    step(1'b0, 2'd2, 4'b0011, 1'b0, 8'h00, "R11");
    // R7: ties resolved by lower index, lower value wins
    step(1'b1, 2'd0, 4'b1010, 1'b1, 8'h00, "R7");
    step(1'b1, 2'd0, 4'b1111, 1'b1, 8'b11_01_01_10, "R7");
    // sweep: every ordered pair of validity patterns
    for (int pi = 0; pi < 4; pi++)
      for (int rv = 0; rv < 2; rv++)
        for (int a = 0; a < 16; a++)
          for (int c = 0; c < 16; c++) begin
            step(1'b1, 2'd0, 4'(a), 1'(rv), pset[pi], "");
            step(1'b1, 2'd0, 4'(c), 1'(rv), pset[pi], "");
          end
    // R9: stable selection gives no pulse
    step(1'b1, 2'd0, 4'b0001, 1'b1, 8'h00, "");
    step(1'b1, 2'd0, 4'b0001, 1'b1, 8'h00, "R9");
    step(1'b1, 2'd0, 4'b0001, 1'b1, 8'h00, "R9");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule